// File: doc/BRIEF.md
# Timed Lookup Table Waveform Player

The player holds a finite waveform in an on-chip table of signed 16-bit converter codes and plays it once, one word at a time. Each word drives a 16-bit two's-complement output to the converter, and a one-cycle strobe marks it. Software first fills the table through a simple write port while the block is idle. It then sets the point count and the spacing between samples in clock ticks, and pulses start.

The read address begins at zero and rises by one for each emitted sample. The spacing between strobes is the programmed period, raised to a floor of 120 clocks. At 25 ns per clock, that floor is the 3 µs the converter needs between updates. The period input is read live, so a new value set during playback governs the next interval without a restart. After the last point the block goes idle and raises done. A bad point count (zero, or more than the table holds) raises an error flag instead of starting playback.

Top module: `wave_player`

## Requirements
- R1: After reset, sampleStb, busy, done and err are 0 and sampleOut is 0.
- R2: When start is high in cycle k while idle with a valid point count, sampleStb is high in cycle k+1 with sampleOut equal to table word 0. busy rises in cycle k+1.
- R3: A playback of N points gives exactly N strobes. Strobe i (counted from 0) presents table word i.
- R4: Each strobe after the first comes exactly max(period, 120) cycles after the previous one. Any period below 120, including 0, acts as 120.
- R5: A period value changed during playback sets the interval that starts at the next strobe. The playback keeps running.
- R6: In the cycle after the Nth strobe, busy falls and done rises. done stays high until the next start pulse.
- R7: Start pulses while busy are ignored, and so is the point count presented with them. The running sequence and its length are unchanged.
- R8: A start with a point count of 0 or above DEPTH sets err in the next cycle and emits no strobe; busy stays 0. The next accepted start clears err.
- R9: Table writes while busy are discarded. Writes while idle store wrData at wrAddr.
- R10: sampleStb is high for one cycle per sample. sampleOut holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, 25 ns nominal |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Table write enable, honoured only while idle |
| wrAddr | input | 10 | Table write address (log2 DEPTH) |
| wrData | input | 16 | Table write data, converter code |
| numPoints | input | 11 | Number of samples to play, 1..DEPTH |
| period | input | 16 | Sample spacing in clocks, floor 120 |
| start | input | 1 | Start pulse |
| sampleOut | output | 16 | Current converter code |
| sampleStb | output | 1 | One-cycle strobe per new sample |
| busy | output | 1 | Playback in progress |
| done | output | 1 | Last playback finished |
| err | output | 1 | Last start was rejected |

## Verification
The assertions check four rules on every cycle. Strobes only occur while busy. Two strobes within one run are never closer than the 120-clock floor. busy rises only right after a start, with the first strobe in that same cycle. done and err never coexist with busy, and done rises only right after a strobe. The bench scenarios are the only way to show the rest. These are that each strobe carries the right table word at the exact cycle the period dictates, and that a mid-run period change moves the next strobe. They also cover ignored starts and ignored writes during playback, and the exact strobe count ending in done.

// File: rtl/wplay_pkg.sv
package wplay_pkg;
  // Per-cycle command from control to datapath
  typedef struct packed {
    logic issue;  // emit a sample this edge
    logic first;  // the sample is table word 0
  } ctrl2dp_t;
endpackage

// File: rtl/wave_ctrl.sv
module wave_ctrl
  import wplay_pkg::*;
#(
  parameter int DEPTH      = 1024,
  parameter int PERIOD_W   = 16,
  parameter int MIN_PERIOD = 120,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [CNT_W-1:0]    numPoints,
  input  logic [PERIOD_W-1:0] period,
  output ctrl2dp_t            strobes,
  output logic                busy,
  output logic                done,
  output logic                err
);
  logic [CNT_W-1:0]    numHeld, sentCnt;
  logic                lastSent;
  logic [PERIOD_W-1:0] timer, effPeriod;
  logic                startOk, startBad, issue;

  always_comb begin
    effPeriod = (period < PERIOD_W'(MIN_PERIOD)) ? PERIOD_W'(MIN_PERIOD) : period;
    startOk   = start && !busy && (numPoints != '0) && (numPoints <= CNT_W'(DEPTH));
    startBad  = start && !busy && !startOk;
    issue     = startOk || (busy && !lastSent && (timer >= effPeriod - PERIOD_W'(1)));
    strobes.issue = issue;
    strobes.first = startOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      numHeld  <= '0;
      sentCnt  <= '0;
      lastSent <= 1'b0;
      timer    <= '0;
    end else begin
      if (startOk) begin
        busy    <= 1'b1;
        done    <= 1'b0;
        err     <= 1'b0;
        numHeld <= numPoints;
      end else if (startBad) begin
        err  <= 1'b1;
        done <= 1'b0;
      end else if (busy && lastSent) begin
        busy <= 1'b0;
        done <= 1'b1;
      end

      if (issue) begin
        timer    <= '0;
        sentCnt  <= startOk ? CNT_W'(1) : sentCnt + CNT_W'(1);
        lastSent <= startOk ? (numPoints == CNT_W'(1))
                            : (sentCnt + CNT_W'(1) == numHeld);
      end else if (busy) begin
        timer <= timer + PERIOD_W'(1);
      end
    end
  end
endmodule

// File: rtl/wave_dp.sv
module wave_dp
  import wplay_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int DATA_W  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busy,
  input  ctrl2dp_t          strobes,
  output logic [DATA_W-1:0] sampleOut,
  output logic              sampleStb
);
  logic [DATA_W-1:0] waveMem [DEPTH];
  logic [ADDR_W-1:0] rdAddr, nextRd;

  always_ff @(posedge clk) begin
    if (wrEn && !busy) waveMem[wrAddr] <= wrData;
  end

  always_comb nextRd = strobes.first ? '0 : rdAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleOut <= '0;
      sampleStb <= 1'b0;
      rdAddr    <= '0;
    end else begin
      sampleStb <= strobes.issue;
      if (strobes.issue) begin
        sampleOut <= waveMem[nextRd];
        rdAddr    <= nextRd + ADDR_W'(1);
      end
    end
  end
endmodule

// File: rtl/wave_player.sv
module wave_player
  import wplay_pkg::*;
#(
  parameter int DEPTH      = 1024,
  parameter int DATA_W     = 16,
  parameter int PERIOD_W   = 16,
  parameter int MIN_PERIOD = 120,
  localparam int ADDR_W    = $clog2(DEPTH),
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [CNT_W-1:0]    numPoints,
  input  logic [PERIOD_W-1:0] period,
  input  logic                start,
  output logic [DATA_W-1:0]   sampleOut,
  output logic                sampleStb,
  output logic                busy,
  output logic                done,
  output logic                err
);
  ctrl2dp_t strobes;

  wave_ctrl #(.DEPTH(DEPTH), .PERIOD_W(PERIOD_W), .MIN_PERIOD(MIN_PERIOD)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .numPoints(numPoints), .period(period),
    .strobes(strobes), .busy(busy), .done(done), .err(err)
  );

  wave_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .busy(busy), .strobes(strobes), .sampleOut(sampleOut), .sampleStb(sampleStb)
  );
endmodule

// File: rtl/wave_player_chk.sv
module wave_player_chk #(
  parameter int MIN_PERIOD = 120
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic sampleStb,
  input logic busy,
  input logic done,
  input logic err
);
  int unsigned gap;
  logic        seen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gap  <= 0;
      seen <= 1'b0;
    end else begin
      gap  <= sampleStb ? 1 : ((gap < 32'hFFFF) ? gap + 1 : gap);
      seen <= sampleStb ? 1'b1 : (busy ? seen : 1'b0);
    end
  end

  AST_STB_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> busy);  // R3
  AST_MIN_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && seen) |-> (gap >= MIN_PERIOD));  // R4
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(start) && sampleStb));  // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);  // R6
  AST_DONE_AFTER_STB: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(sampleStb));  // R6
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (!busy && !sampleStb));  // R8
endmodule

bind wave_player wave_player_chk #(.MIN_PERIOD(MIN_PERIOD)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .sampleStb(sampleStb),
  .busy(busy), .done(done), .err(err)
);

// File: tb/wave_player_tb_top.sv
module wave_player_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 1024;
  localparam int MIN_P      = 120;
  localparam int ADDR_W     = $clog2(DEPTH);
  localparam int CNT_W      = $clog2(DEPTH + 1);

  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0, start = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [CNT_W-1:0] numPoints = '0;
  logic [15:0] period = '0;
  logic [15:0] sampleOut;
  logic sampleStb, busy, done, err;

  logic [15:0] model [DEPTH];
  int checks = 0, failures = 0;
  int cyc = 0;

  wave_player dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .numPoints(numPoints), .period(period), .start(start),
    .sampleOut(sampleOut), .sampleStb(sampleStb), .busy(busy), .done(done), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int effP(int p);
    return (p < MIN_P) ? MIN_P : p;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic writeWord(int addr, logic [15:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = ADDR_W'(addr); wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
    model[addr] = val;
  endtask

  // Plays n points; returns strobes seen after the nth within a quiet window
  task automatic runPlay(int n, int p, int pNew, int changeAt,
                         bit injStart, bit injWrite, output int extra);
    int t, idx, nextT, lastVal;
    bit holdOk, clearPend;
    string tag;
    idx = 0; nextT = 1; lastVal = 0; holdOk = 1; clearPend = 0; extra = 0;
    @(negedge clk);
    numPoints = CNT_W'(n); period = 16'(p); start = 1'b1;
    @(negedge clk);
    start = 1'b0; t = 1;
    check(err == 1'b0 && busy == 1'b1, "R8", "err cleared, busy set by valid start", err, 0);
    while (idx < n && t < 100000) begin
      if (clearPend) begin start = 1'b0; wrEn = 1'b0; clearPend = 0; end
      if (sampleStb) begin
        tag = (idx == 0) ? "R2" : ((changeAt > 0 && idx > changeAt) ? "R5" : "R4");
        check(t == nextT, tag, "strobe cycle", t, nextT);
        check(sampleOut == model[idx], "R3", "sample word", sampleOut, model[idx]);
        lastVal = model[idx];
        idx++;
        if (idx == changeAt) period = 16'(pNew);
        nextT = t + effP(int'(period));
        if (idx == 2 && injStart) begin
          start = 1'b1; numPoints = CNT_W'(n + 5); clearPend = 1;
        end
        if (idx == 2 && injWrite) begin
          wrEn = 1'b1; wrAddr = '0; wrData = ~model[0]; clearPend = 1;
        end
      end else if (idx > 0 && sampleOut != 16'(lastVal)) begin
        holdOk = 0;
      end
      if (idx < n) begin @(negedge clk); t++; end
    end
    check(idx == n, "R3", "strobe count", idx, n);
    check(done == 1'b0 && busy == 1'b1, "R6", "still busy in last strobe cycle", done, 0);
    @(negedge clk);
    if (clearPend) begin start = 1'b0; wrEn = 1'b0; end
    check(done == 1'b1 && busy == 1'b0, "R6", "done after last strobe", done, 1);
    check(sampleStb == 1'b0 && sampleOut == 16'(lastVal), "R10", "single-cycle strobe, value held", sampleStb, 0);
    for (int k = 0; k < 150; k++) begin
      @(negedge clk);
      if (sampleStb) extra++;
      if (!done || sampleOut != 16'(lastVal)) holdOk = 0;
    end
    check(holdOk, "R10", "output and done held", holdOk, 1);
  endtask

  task automatic rejectPlay(int n);
    int stb;
    stb = 0;
    @(negedge clk);
    numPoints = CNT_W'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(err == 1'b1 && busy == 1'b0 && done == 1'b0, "R8", "rejected count raises err", err, 1);
    for (int k = 0; k < 130; k++) begin
      @(negedge clk);
      if (sampleStb || busy) stb++;
    end
    check(stb == 0, "R8", "no playback after reject", stb, 0);
  endtask

  initial begin
    int extra, n, p;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(sampleStb == 0 && busy == 0 && done == 0 && err == 0 && sampleOut == 0,
          "R1", "reset state", {sampleStb, busy, done, err}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // Table: +5 V and -5 V codes, then random words
    writeWord(0, 16'h4000);
    writeWord(1, 16'hC000);
    for (int a = 2; a < 40; a++) writeWord(a, 16'($urandom));

    // Period below the floor acts as 120
    runPlay(3, 10, 10, 0, 0, 0, extra);
    check(extra == 0, "R3", "no extra strobes", extra, 0);
    // Zero period also clamps
    runPlay(2, 0, 0, 0, 0, 0, extra);
    // Long period, shortened mid-run
    runPlay(5, 300, 130, 2, 0, 0, extra);
    check(extra == 0, "R5", "run continues after period change", extra, 0);
    // Lengthened mid-run
    runPlay(4, 125, 260, 1, 0, 0, extra);
    // Single point
    runPlay(1, 200, 200, 0, 0, 0, extra);
    check(extra == 0, "R6", "single point ends", extra, 0);
    // Start while busy ignored
    runPlay(6, 140, 140, 0, 1, 0, extra);
    check(extra == 0, "R7", "busy start ignored, length kept", extra, 0);
    // Write while busy ignored
    runPlay(4, 130, 130, 0, 0, 1, extra);
    runPlay(1, 120, 120, 0, 0, 0, extra);
    check(sampleOut == model[0], "R9", "word 0 kept after busy write", sampleOut, model[0]);
    // Idle write takes effect
    writeWord(0, 16'h1234);
    runPlay(1, 120, 120, 0, 0, 0, extra);
    check(sampleOut == 16'h1234, "R9", "idle write stored", sampleOut, 16'h1234);

    // Rejections and recovery
    rejectPlay(0);
    rejectPlay(DEPTH + 1);
    runPlay(2, 121, 121, 0, 0, 0, extra);

    // Random runs
    for (int r = 0; r < 6; r++) begin
      n = 1 + int'($urandom % 24);
      p = 60 + int'($urandom % 200);
      runPlay(n, p, 100 + int'($urandom % 150), 1 + int'($urandom % n), 0, 0, extra);
      check(extra == 0, "R3", "random run length", extra, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule